// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block keeps frame time for a full-speed USB host. While the host is operational it counts the bit times left in the current frame. When the count is exhausted it reloads from a software-programmed interval and advances a 16-bit frame number. Each new frame produces a one-cycle start-of-frame pulse. A separate one-cycle pulse fires whenever the top bit of the frame number flips in either direction.

Software writes the interval, a toggle bit and a largest-packet value. The block picks these up only at a frame boundary. The toggle is copied into a readable status bit at that point, so software can tell when a new interval has taken effect. Two live comparisons against the remaining count guide the scheduler. One says whether periodic list processing may begin. The other says whether a low-speed transaction may still be started.

When the run enable rises, the first frame starts only after a programmable number of bit times, which is 1 ms worth by default.

Top module: `usb_frame_timer`

## Requirements
- R1: During and after synchronous reset, `remain`, `remain_toggle`, `frame_num` and `pkt_budget` are 0, and `sof_pulse`, `fno_pulse`, `periodic_ok` and `ls_ok` are 0.
- R2: After `run` is first seen high at a clock edge, the first frame start happens on the START_TICKS-th `bit_tick`, counted from the following edges. No `sof_pulse` appears before it.
- R3: While the timer is running, every `bit_tick` with `remain` non-zero lowers `remain` by exactly one. Without `bit_tick`, `remain` holds its value.
- R4: A `bit_tick` while `remain` is 0 starts a new frame and loads `cfg_interval` into `remain`, so a frame lasts `cfg_interval`+1 bit ticks. Changing `cfg_interval` mid-frame has no effect until that reload.
- R5: At every frame start, `remain_toggle` takes the value of `cfg_toggle`. It holds between frame starts.
- R6: `frame_num` increases by one, modulo 2^16, at every frame start, including the first.
- R7: `sof_pulse` is high for exactly the one cycle after each frame start and low otherwise.
- R8: `fno_pulse` is high for the one cycle after a frame start in which bit 15 of `frame_num` changed. This covers 0x7FFF to 0x8000 and 0xFFFF to 0x0000.
- R9: `pkt_budget` takes `cfg_maxpkt` at every frame start and holds until the next.
- R10: `periodic_ok` is high exactly when the timer is running and `remain` is less than or equal to `cfg_pstart`.
- R11: `ls_ok` is high exactly when the timer is running and `remain` is greater than or equal to `cfg_ls_thr`, zero-extended.
- R12: Dropping `run` stops the timer. `remain`, `frame_num`, `remain_toggle` and `pkt_budget` hold, and no pulses appear. Raising `run` again restarts the full startup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| run | input | 1 | High while the host is operational |
| cfg_interval | input | 14 | Frame interval in bit times minus one |
| cfg_toggle | input | 1 | Interval toggle written by software |
| cfg_maxpkt | input | 15 | Largest-packet value loaded per frame |
| cfg_pstart | input | 14 | Remaining-count point where periodic work may begin |
| cfg_ls_thr | input | 12 | Minimum remaining count for a low-speed start |
| remain | output | 14 | Bit times left in the current frame |
| remain_toggle | output | 1 | Toggle captured at the last frame start |
| frame_num | output | 16 | Frame number |
| pkt_budget | output | 15 | Largest-packet value captured at frame start |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| fno_pulse | output | 1 | One-cycle frame-number top-bit flip pulse |
| periodic_ok | output | 1 | Periodic processing allowed |
| ls_ok | output | 1 | Low-speed transaction may start |

## Verification
The hardest condition to reach is the top-bit flip of the frame number. It needs 32768 frames for 0x7FFF to 0x8000 and 65536 for the wrap to zero. The stimulus programs an interval of 0 and ticks every cycle, so each bit tick is a whole frame. Both flips then arrive within about 66k cycles, and the bench counts exactly two overflow pulses. A behavioural model compares every output on every cycle. This includes irregular tick patterns, an interval change in mid-frame, a pause of the run enable and threshold values at both extremes.

// File: rtl/ft_pkg.sv
package ft_pkg;

    typedef enum logic [1:0] {
        FT_IDLE = 2'd0,
        FT_WAIT = 2'd1,
        FT_RUN  = 2'd2
    } ft_state_e;

    typedef struct packed {
        logic sof;
        logic fno;
    } ft_event_t;

    function automatic logic msb_flipped(input logic old_msb, input logic new_msb);
        return old_msb ^ new_msb;
    endfunction

endpackage

// File: rtl/ft_startup.sv
module ft_startup #(
    parameter int START_TICKS = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_tick,
    output logic first_start,
    output logic running,
    output logic step_en
);
    import ft_pkg::*;

    localparam int CNT_W = (START_TICKS > 1) ? $clog2(START_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_TICKS - 1);

    ft_state_e        state;
    logic [CNT_W-1:0] dly;

    assign first_start = (state == FT_WAIT) && run && bit_tick && (dly == LAST);
    assign running     = (state == FT_RUN);
    assign step_en     = running && run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FT_IDLE;
            dly   <= '0;
        end else if (!run) begin
            state <= FT_IDLE;
            dly   <= '0;
        end else begin
            unique case (state)
                FT_IDLE: begin
                    state <= FT_WAIT;
                    dly   <= '0;
                end
                FT_WAIT: begin
                    if (bit_tick) begin
                        if (dly == LAST) state <= FT_RUN;
                        else             dly   <= dly + 1'b1;
                    end
                end
                default: state <= FT_RUN;
            endcase
        end
    end

    // R12: a low run enable always returns the sequencer to idle
    p_idle_when_off_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> (state == FT_IDLE));

    // R2: the running state is entered only through a counted start
    p_enter_run_r2: assert property (@(posedge clk) disable iff (rst)
        (!running && !first_start) |=> !running);

endmodule

// File: rtl/ft_frame_ctr.sv
module ft_frame_ctr #(
    parameter int REM_W = 14,
    parameter int PKT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             step_en,
    input  logic             first_start,
    input  logic [REM_W-1:0] cfg_interval,
    input  logic             cfg_toggle,
    input  logic [PKT_W-1:0] cfg_maxpkt,
    output logic [REM_W-1:0] remain,
    output logic             remain_toggle,
    output logic [PKT_W-1:0] pkt_budget,
    output logic             frame_start
);

    logic expired;

    assign expired     = step_en && bit_tick && (remain == '0);
    assign frame_start = first_start || expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain        <= '0;
            remain_toggle <= 1'b0;
            pkt_budget    <= '0;
        end else if (frame_start) begin
            remain        <= cfg_interval;
            remain_toggle <= cfg_toggle;
            pkt_budget    <= cfg_maxpkt;
        end else if (step_en && bit_tick) begin
            remain        <= remain - 1'b1;
        end
    end

    // R3: one step down per bit time while running
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && bit_tick && remain != '0) |=> (remain == $past(remain) - 1'b1));

    // R3: no bit time, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(remain));

    // R9: packet budget changes only at a frame start
    p_pkt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(pkt_budget));

endmodule

// File: rtl/ft_number.sv
module ft_number #(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_start,
    output logic [FN_W-1:0] frame_num,
    output ft_pkg::ft_event_t evt
);
    import ft_pkg::*;

    logic [FN_W-1:0] num_next;

    assign num_next = frame_num + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_num <= '0;
            evt       <= '0;
        end else begin
            evt.sof <= frame_start;
            evt.fno <= frame_start && msb_flipped(frame_num[FN_W-1], num_next[FN_W-1]);
            if (frame_start) frame_num <= num_next;
        end
    end

    // R6: the number advances by one on each frame start
    p_count_up_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (frame_num == $past(frame_num) + 1'b1));

    // R8: an overflow pulse never appears without a start-of-frame pulse
    p_fno_with_sof_r8: assert property (@(posedge clk) disable iff (rst)
        evt.fno |-> evt.sof);

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
    parameter int REM_W       = 14,
    parameter int FN_W        = 16,
    parameter int PKT_W       = 15,
    parameter int LS_W        = 12,
    parameter int START_TICKS = 12000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             run,
    input  logic [REM_W-1:0] cfg_interval,
    input  logic             cfg_toggle,
    input  logic [PKT_W-1:0] cfg_maxpkt,
    input  logic [REM_W-1:0] cfg_pstart,
    input  logic [LS_W-1:0]  cfg_ls_thr,
    output logic [REM_W-1:0] remain,
    output logic             remain_toggle,
    output logic [FN_W-1:0]  frame_num,
    output logic [PKT_W-1:0] pkt_budget,
    output logic             sof_pulse,
    output logic             fno_pulse,
    output logic             periodic_ok,
    output logic             ls_ok
);
    import ft_pkg::*;

    logic      first_start;
    logic      running;
    logic      step_en;
    logic      frame_start;
    ft_event_t evt;

    ft_startup #(.START_TICKS(START_TICKS)) u_startup (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .bit_tick    (bit_tick),
        .first_start (first_start),
        .running     (running),
        .step_en     (step_en)
    );

    ft_frame_ctr #(.REM_W(REM_W), .PKT_W(PKT_W)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .step_en       (step_en),
        .first_start   (first_start),
        .cfg_interval  (cfg_interval),
        .cfg_toggle    (cfg_toggle),
        .cfg_maxpkt    (cfg_maxpkt),
        .remain        (remain),
        .remain_toggle (remain_toggle),
        .pkt_budget    (pkt_budget),
        .frame_start   (frame_start)
    );

    ft_number #(.FN_W(FN_W)) u_number (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_num   (frame_num),
        .evt         (evt)
    );

    assign sof_pulse   = evt.sof;
    assign fno_pulse   = evt.fno;

    generate
        if (LS_W < REM_W) begin : g_ls_ext
            assign ls_ok = running && (remain >= {{(REM_W-LS_W){1'b0}}, cfg_ls_thr});
        end else begin : g_ls_trunc
            assign ls_ok = running && ({{(LS_W-REM_W){1'b0}}, remain} >= cfg_ls_thr);
        end
    endgenerate

    assign periodic_ok = running && (remain <= cfg_pstart);

    // R4: a start-of-frame pulse shows the freshly loaded interval
    p_sof_reload_r4: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> (remain == $past(cfg_interval)));

    // R5: the toggle follows the software bit at each frame start
    p_toggle_copy_r5: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> (remain_toggle == $past(cfg_toggle)));

    // R12: with run low the frame number does not move
    p_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(frame_num));

endmodule

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;

    localparam int ST = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick;
    logic        run;
    logic [13:0] cfg_interval;
    logic        cfg_toggle;
    logic [14:0] cfg_maxpkt;
    logic [13:0] cfg_pstart;
    logic [11:0] cfg_ls_thr;
    logic [13:0] remain;
    logic        remain_toggle;
    logic [15:0] frame_num;
    logic [14:0] pkt_budget;
    logic        sof_pulse, fno_pulse, periodic_ok, ls_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    usb_frame_timer #(.START_TICKS(ST)) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .run(run),
        .cfg_interval(cfg_interval), .cfg_toggle(cfg_toggle), .cfg_maxpkt(cfg_maxpkt),
        .cfg_pstart(cfg_pstart), .cfg_ls_thr(cfg_ls_thr),
        .remain(remain), .remain_toggle(remain_toggle), .frame_num(frame_num),
        .pkt_budget(pkt_budget), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse),
        .periodic_ok(periodic_ok), .ls_ok(ls_ok)
    );

    // behavioural reference model: 0 idle, 1 waiting, 2 running
    int m_state, m_dly, m_rem, m_tog, m_num, m_pkt, m_sof, m_fno;
    int fno_seen;

    task automatic begin_frame();
        int old_msb;
        old_msb = m_num / 32768;
        m_rem = cfg_interval;
        m_tog = cfg_toggle;
        m_num = (m_num + 1) % 65536;
        m_pkt = cfg_maxpkt;
        m_sof = 1;
        m_fno = ((m_num / 32768) != old_msb) ? 1 : 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_dly = 0; m_rem = 0; m_tog = 0;
            m_num = 0; m_pkt = 0; m_sof = 0; m_fno = 0;
        end else begin
            m_sof = 0;
            m_fno = 0;
            if (!run) begin
                m_state = 0;
                m_dly = 0;
            end else if (m_state == 0) begin
                m_state = 1;
                m_dly = 0;
            end else if (m_state == 1) begin
                if (bit_tick) begin
                    if (m_dly == ST - 1) begin
                        m_state = 2;
                        begin_frame();
                    end else begin
                        m_dly++;
                    end
                end
            end else if (bit_tick) begin
                if (m_rem == 0) begin_frame();
                else m_rem--;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3/R4 remain", int'(remain), m_rem);
            check("R5 remain_toggle", int'(remain_toggle), m_tog);
            check("R6 frame_num", int'(frame_num), m_num);
            check("R7 sof_pulse", int'(sof_pulse), m_sof);
            check("R8 fno_pulse", int'(fno_pulse), m_fno);
            check("R9 pkt_budget", int'(pkt_budget), m_pkt);
            check("R10 periodic_ok", int'(periodic_ok), (m_state == 2 && m_rem <= int'(cfg_pstart)) ? 1 : 0);
            check("R11 ls_ok", int'(ls_ok), (m_state == 2 && m_rem >= int'(cfg_ls_thr)) ? 1 : 0);
            if (fno_pulse) fno_seen++;
        end
    end

    task automatic step(input bit tk);
        @(negedge clk);
        #2;
        bit_tick = tk;
    endtask

    initial begin
        rst = 1'b1; bit_tick = 1'b0; run = 1'b0;
        cfg_interval = 14'd9; cfg_toggle = 1'b1; cfg_maxpkt = 15'd100;
        cfg_pstart = 14'd6; cfg_ls_thr = 12'd3;
        fno_seen = 0;
        repeat (4) @(posedge clk);
        #2;
        // R1: reset values
        check("R1 remain", int'(remain), 0);
        check("R1 frame_num", int'(frame_num), 0);
        check("R1 pkt_budget", int'(pkt_budget), 0);
        check("R1 pulses", int'(sof_pulse) + int'(fno_pulse) + int'(periodic_ok) + int'(ls_ok), 0);
        @(negedge clk); #2; rst = 1'b0;

        // R2: first frame after ST counted ticks
        begin
            int edges;
            edges = 0;
            run = 1'b1; bit_tick = 1'b1;
            while (!sof_pulse && edges < 200) begin
                @(posedge clk); #2; edges++;
            end
            check("R2 startup edges", edges, ST + 1);
        end

        // R3/R4/R9: irregular ticks, interval change mid-frame
        for (int i = 0; i < 120; i++) begin
            if (i == 13) begin cfg_interval = 14'd4; cfg_toggle = 1'b0; cfg_maxpkt = 15'd7; end
            if (i == 60) begin cfg_pstart = 14'd0; cfg_ls_thr = 12'd4095; end
            if (i == 90) begin cfg_pstart = 14'd16383; cfg_ls_thr = 12'd0; cfg_toggle = 1'b1; end
            step((i % 3) != 1);
        end

        // R12: pause the run enable, everything holds
        begin
            int held_num;
            step(1'b1);
            run = 1'b0;
            @(posedge clk); #2;
            held_num = frame_num;
            for (int i = 0; i < 12; i++) step(1'b1);
            check("R12 frame_num frozen", int'(frame_num), held_num);
            run = 1'b1;
            for (int i = 0; i < ST + 20; i++) step(1'b1);
        end

        // R8: one-tick frames to reach both top-bit flips
        cfg_interval = 14'd0;
        cfg_pstart = 14'd0;
        cfg_ls_thr = 12'd0;
        fno_seen = 0;
        for (int i = 0; i < 66000; i++) step(1'b1);
        check("R8 overflow pulses", fno_seen, 2);

        step(1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule